// File: doc/BRIEF.md
# Sector Write Buffer Controller

This block is the page-program front end of a sector-organised nonvolatile memory, written as synchronous logic. A host first issues a three-write unlock command. It then sends byte-load strobes, each with an address and a data byte. The block gathers one sector of bytes in an internal latch array. A per-offset valid bitmap records which bytes were loaded. The sector is chosen by the first load of the operation.

There is no explicit start command. The block counts the clock cycles since the last accepted load. When the gap exceeds a set window, loading closes and a program cycle of fixed length begins, with `busy` held high. At the end of that cycle the whole sector of a behavioural storage array is replaced in one step. Each loaded offset takes its latched byte, and every other offset becomes FFh, as if the sector had been erased first. A registered read port returns the array contents at any time.

Top module: `sector_wbuf`

## Requirements
- R1: After reset, `busy` and `sect_err` are low and every array byte reads FFh.
- R2: A load is accepted only after an unlock made of three strobes in sequence: AAh to address `UNLK_A`, then 55h to `UNLK_B`, then A0h to `UNLK_A`. A wrong strobe in the sequence returns to idle. Loads that are not preceded by an unlock change no byte and do not raise `busy`.
- R3: Within one operation, bytes may be loaded at any offsets in any order. The low `OFF_W` address bits give the offset and the upper bits give the sector. After the commit each loaded offset holds its data. If an offset is loaded more than once, the last value loaded is kept.
- R4: A load sampled at most `LOAD_WIN` cycles after the previous accepted load keeps the load phase open. If `LOAD_WIN` cycles pass with no accepted load after the last accepted load, `busy` is high from the following cycle.
- R5: `busy` stays high for exactly `PROG_CYC` cycles. The array keeps its old contents while `busy` is high, and the sector is committed when `busy` falls.
- R6: After the commit, every offset of the sector that was not loaded in the operation reads FFh, even if it held data before.
- R7: A load whose sector differs from the first load of the operation is ignored and sets `sect_err`. `sect_err` then stays high until reset.
- R8: Loads that arrive while `busy` is high are ignored.
- R9: The valid bitmap is cleared by every unlock. Bytes loaded in an earlier operation are therefore not committed again.
- R10: A commit leaves all other sectors unchanged.
- R11: `rd_data` shows the byte at `rd_addr` one cycle after `rd_addr` is sampled.
- R12: If no byte is loaded within `LOAD_WIN` cycles of the unlock, the block returns to idle with no program cycle, and a later load needs a new unlock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ld_stb | input | 1 | Byte-load strobe, one cycle per load |
| ld_addr | input | ADDR_W | Load address: sector in the upper bits, offset in the low OFF_W bits |
| ld_data | input | 8 | Load data byte |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Registered read data |
| busy | output | 1 | High during the internal program cycle |
| sect_err | output | 1 | Sticky flag for a load to a foreign sector |

## Verification
The load path is driven with several patterns:
- Loads without any unlock, and a broken unlock sequence. These show that the protection gate holds.
- An out-of-order sector load that includes a repeated offset and both edge offsets. This separates correct offset placement from sequential filling and checks that the last write to an offset wins.
- A load placed exactly at the window limit, and a run left idle past it. Together these pin the timeout to the exact cycle.
- A second, sparser operation on the same sector, which carries one foreign-sector load. This shows whether the bitmap was cleared and whether the foreign load was dropped.

Further checks cover reads during the program cycle, loads sent while busy, the top sector, and an unlock left idle. These confirm that the array changes only at the commit, and only inside the chosen sector.

// File: rtl/sector_wbuf.sv
module sector_wbuf #(
  parameter int ADDR_W   = 10,
  parameter int OFF_W    = 8,
  parameter int LOAD_WIN = 3750,
  parameter int PROG_CYC = 500000,
  parameter logic [ADDR_W-1:0] UNLK_A = 'h155,
  parameter logic [ADDR_W-1:0] UNLK_B = 'h2AA
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ld_stb,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              sect_err
);
  localparam int SEC_W  = ADDR_W - OFF_W;
  localparam int NBYTES = 1 << OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;
  localparam int CMAX   = (LOAD_WIN > PROG_CYC) ? LOAD_WIN : PROG_CYC;
  localparam int CNT_W  = $clog2(CMAX + 1);

  typedef enum logic [2:0] {S_IDLE, S_U1, S_U2, S_ARM, S_FILL, S_PROG} state_t;

  state_t             state_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [SEC_W-1:0]   sec_q;
  logic [NBYTES-1:0]  vld_q;
  logic               err_q;
  logic [7:0]         rd_q;
  logic [7:0]         buf_q [NBYTES];
  logic [7:0]         mem   [DEPTH];

  wire [SEC_W-1:0] ld_sec  = ld_addr[ADDR_W-1:OFF_W];
  wire [OFF_W-1:0] ld_off  = ld_addr[OFF_W-1:0];
  wire             is_a    = ld_stb && (ld_addr == UNLK_A);
  wire             is_b    = ld_stb && (ld_addr == UNLK_B);
  wire             load_ok = ld_stb && ((state_q == S_ARM) ||
                                        (state_q == S_FILL && ld_sec == sec_q));
  wire             win_end  = cnt_q == CNT_W'(LOAD_WIN - 1);
  wire             prog_end = (state_q == S_PROG) && (cnt_q == CNT_W'(PROG_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      sec_q   <= '0;
      vld_q   <= '0;
      err_q   <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (is_a && ld_data == 8'hAA) state_q <= S_U1;
        S_U1:   if (ld_stb) state_q <= (is_b && ld_data == 8'h55) ? S_U2 : S_IDLE;
        S_U2:   if (ld_stb) begin
          if (is_a && ld_data == 8'hA0) begin
            state_q <= S_ARM;
            cnt_q   <= '0;
            vld_q   <= '0;
          end else begin
            state_q <= S_IDLE;
          end
        end
        S_ARM: begin
          if (ld_stb) begin
            sec_q         <= ld_sec;
            vld_q[ld_off] <= 1'b1;
            cnt_q         <= '0;
            state_q       <= S_FILL;
          end else if (win_end) begin
            state_q <= S_IDLE;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        S_FILL: begin
          if (load_ok) begin
            vld_q[ld_off] <= 1'b1;
            cnt_q         <= '0;
          end else begin
            if (ld_stb) err_q <= 1'b1;
            if (win_end) begin
              state_q <= S_PROG;
              cnt_q   <= '0;
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
        end
        S_PROG: begin
          if (prog_end) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (load_ok) buf_q[ld_off] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      rd_q <= 8'hFF;
    end else begin
      if (prog_end) begin
        for (int i = 0; i < NBYTES; i++)
          mem[{sec_q, OFF_W'(i)}] <= vld_q[i] ? buf_q[i] : 8'hFF;
      end
      rd_q <= mem[rd_addr];
    end
  end

  assign rd_data  = rd_q;
  assign busy     = (state_q == S_PROG);
  assign sect_err = err_q;
endmodule

// File: rtl/sector_wbuf_chk.sv
module sector_wbuf_chk #(
  parameter int PROG_CYC = 500000
) (
  input logic clk,
  input logic rst_n,
  input logic ld_stb,
  input logic busy,
  input logic sect_err
);
  int busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_run <= 0;
    else if (busy) busy_run <= busy_run + 1;
    else           busy_run <= 0;
  end

  assert_reset_clear_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (!busy && !sect_err));

  assert_busy_after_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> !$past(ld_stb));

  assert_busy_length_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == PROG_CYC));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    sect_err |=> sect_err);

  assert_err_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sect_err) |-> $past(ld_stb));
endmodule

bind sector_wbuf sector_wbuf_chk #(.PROG_CYC(PROG_CYC)) chk_i (
  .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .busy(busy), .sect_err(sect_err)
);

// File: tb/sector_wbuf_tb_top.sv
module sector_wbuf_tb_top;
  localparam int AW = 10;
  localparam int W  = 12;
  localparam int P  = 40;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ld_stb = 1'b0;
  logic [AW-1:0] ld_addr = '0;
  logic [7:0]    ld_data = '0;
  logic [AW-1:0] rd_addr = '0;
  logic [7:0]    rd_data;
  logic          busy;
  logic          sect_err;

  int n_chk = 0;
  int n_fail = 0;

  typedef struct { logic [AW-1:0] a; logic [7:0] e; string tag; } rd_item_t;
  rd_item_t exp_q[$];
  rd_item_t infl;
  bit       infl_v = 1'b0;

  always #5 clk = ~clk;

  sector_wbuf #(.ADDR_W(AW), .OFF_W(8), .LOAD_WIN(W), .PROG_CYC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .ld_stb(ld_stb), .ld_addr(ld_addr), .ld_data(ld_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .sect_err(sect_err)
  );

  always @(posedge clk) begin
    if (exp_q.size() > 0) begin
      infl   <= exp_q.pop_front();
      infl_v <= 1'b1;
    end else begin
      infl_v <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (infl_v) begin
      n_chk++;
      if (rd_data !== infl.e) begin
        n_fail++;
        $display("FAIL %s: read %h got %h expected %h", infl.tag, infl.a, rd_data, infl.e);
      end
    end
  end

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [AW-1:0] a, input logic [7:0] e, input string tag);
    rd_item_t it;
    @(negedge clk);
    rd_addr = a;
    it.a = a; it.e = e; it.tag = tag;
    exp_q.push_back(it);
  endtask

  task automatic rd_done();
    repeat (3) @(negedge clk);
  endtask

  task automatic ld(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    ld_stb = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_stb = 1'b0;
  endtask

  task automatic unlock();
    ld(10'h155, 8'hAA);
    ld(10'h2AA, 8'h55);
    ld(10'h155, 8'hA0);
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic run_all();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 busy", {7'd0, busy}, 8'd0);
    chk("R1 sect_err", {7'd0, sect_err}, 8'd0);
    rd(10'h000, 8'hFF, "R1 R11");
    rd(10'h1A5, 8'hFF, "R1");
    rd(10'h3FF, 8'hFF, "R1");
    rd_done();

    // R2: no unlock
    ld(10'h105, 8'h12);
    repeat (2 * W) @(negedge clk);
    chk("R2 busy without unlock", {7'd0, busy}, 8'd0);
    // R2: broken sequence
    ld(10'h155, 8'hAA);
    ld(10'h2AA, 8'h54);
    ld(10'h155, 8'hA0);
    ld(10'h106, 8'h34);
    repeat (2 * W) @(negedge clk);
    chk("R2 busy after bad unlock", {7'd0, busy}, 8'd0);
    rd(10'h105, 8'hFF, "R2");
    rd(10'h106, 8'hFF, "R2");
    rd_done();

    // Op A: sector 1, out of order, repeated offset, window boundary
    unlock();
    ld(10'h180, 8'h11);
    ld(10'h103, 8'h22);
    ld(10'h1FF, 8'h33);
    repeat (W - 2) @(negedge clk);
    ld(10'h100, 8'h44);            // sampled exactly W cycles after previous (R4)
    chk("R4 busy low at window limit", {7'd0, busy}, 8'd0);
    ld(10'h103, 8'h55);
    repeat (W - 1) @(negedge clk);
    chk("R4 busy low before timeout", {7'd0, busy}, 8'd0);
    @(negedge clk);
    chk("R4 busy high after timeout", {7'd0, busy}, 8'd1);
    ld(10'h110, 8'h99);            // R8: ignored while busy
    rd(10'h180, 8'hFF, "R5 array unchanged while busy");
    rd_done();
    repeat (P - 7) @(negedge clk);
    chk("R5 busy still high", {7'd0, busy}, 8'd1);
    @(negedge clk);
    chk("R5 busy low after PROG_CYC", {7'd0, busy}, 8'd0);
    rd(10'h180, 8'h11, "R3");
    rd(10'h103, 8'h55, "R3 last wins");
    rd(10'h1FF, 8'h33, "R3");
    rd(10'h100, 8'h44, "R3");
    rd(10'h110, 8'hFF, "R8");
    rd(10'h101, 8'hFF, "R6");
    rd(10'h0FF, 8'hFF, "R10");
    rd(10'h200, 8'hFF, "R10");
    rd_done();
    chk("R7 no error yet", {7'd0, sect_err}, 8'd0);

    // Op B: same sector, sparse, one foreign-sector load
    unlock();
    ld(10'h103, 8'h66);
    ld(10'h200, 8'h77);
    chk("R7 error set", {7'd0, sect_err}, 8'd1);
    repeat (W + 2) @(negedge clk);
    wait_idle();
    rd(10'h103, 8'h66, "R9");
    rd(10'h180, 8'hFF, "R9 old byte erased");
    rd(10'h100, 8'hFF, "R6 R9");
    rd(10'h200, 8'hFF, "R7 foreign load dropped");
    rd_done();
    chk("R7 error sticky", {7'd0, sect_err}, 8'd1);

    // Op C: top sector
    unlock();
    ld(10'h3FF, 8'hA5);
    repeat (W + 2) @(negedge clk);
    wait_idle();
    rd(10'h3FF, 8'hA5, "R3 top sector");
    rd(10'h3FE, 8'hFF, "R6");
    rd(10'h103, 8'h66, "R10");
    rd_done();

    // R12: unlock with no load
    unlock();
    repeat (2 * W) @(negedge clk);
    chk("R12 busy after idle unlock", {7'd0, busy}, 8'd0);
    ld(10'h020, 8'h5A);
    repeat (2 * W) @(negedge clk);
    chk("R12 busy after stale load", {7'd0, busy}, 8'd0);
    rd(10'h020, 8'hFF, "R12");
    rd_done();
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule